// File: doc/BRIEF.md
# Time-of-Day Calendar Counter

This block holds the running wall-clock state of a chip: seconds, minutes, hours, day of week, day of month, month, year and century, each as an 8-bit register. A free-running low-frequency tick enable (nominally 32768 ticks per second) feeds a prescaler. Each time the prescaler completes a second, the whole register set advances by one second in a single clock cycle, with carries rippling up to the century.

Software-facing logic sits outside this block. That logic supplies the control bits: a freeze bit, a 3-bit divider field, the number format and the hour format. It writes registers through per-register load strobes. It watches two outputs: an update-warning flag, raised shortly before every advance, and a one-cycle pulse marking each advance. The registers hold either plain binary or packed decimal (tens digit in the upper nibble). Hours are kept either as 0–23 or as 1–12 with a PM flag.

Top module: `tod_calendar`

## Requirements
- R1: With the freeze bit low and the divider field at 000, 001 or 010, the registers advance by one second on the TICKS_PER_SEC-th counted tick. After reset the prescaler phase is zero, so the first advance occurs on the TICKS_PER_SEC-th tick.
- R2: `uip` is 1 while the prescaler count is at least TICKS_PER_SEC-UIP_TICKS, which covers the last UIP_TICKS tick intervals before each advance. It is 0 at all other times, and it is 0 whenever the freeze bit is high or the divider field is outside 000–010. No input writes it directly.
- R3: A divider field of 110 or 111 holds the prescaler in reset. While it is held, no advance occurs and `uip` is 0. When the field returns to 000–010, the first advance comes after TICKS_PER_SEC/2 ticks.
- R4: A divider field of 011, 100 or 101 stops the prescaler without resetting it. Ticks are ignored and no advance occurs. Counting resumes from the same phase once the field is valid again.
- R5: While `setHold` is 1 the prescaler keeps its phase, but the time registers do not advance and `updEnded` stays 0.
- R6: With `dataBinary` = 1 the registers hold plain binary values. With `dataBinary` = 0 they hold packed decimal, for example 45 is 0x45.
- R7: With `hour24` = 0 the hours register holds 1–12 in its low seven bits, with bit 7 set for PM. Midnight is 12 with bit 7 clear, and noon is 12 with bit 7 set. With `hour24` = 1 it holds 0–23.
- R8: Seconds 59 wrap to 0 and carry into minutes. Minutes 59 wrap to 0 and carry into hours. Hour 23 wraps to 0 and carries a day. All of these carries take effect in the same cycle as the advance.
- R9: Day of month wraps to 1 after 30 in months 4, 6, 9 and 11, and after 31 in the other months except month 2. Month 2 wraps after 29 in a leap year and after 28 otherwise. The leap test uses the full year century*100+year: divisible by 4, and not by 100 unless also by 400.
- R10: Day of week wraps 7→1 on each day carry. Month wraps 12→1 and carries into year. Year wraps 99→0 and carries into century.
- R11: Register index order for `wrEn` is 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century. A set `wrEn[i]` loads `wrData` into register i on the next clock edge. This write takes priority over an advance in the same cycle, while the other registers still advance.
- R12: `updEnded` is a one-cycle pulse, visible in the same cycle that the advanced register values first appear.
- R13: After reset, the seconds, minutes, hours, year and century registers are 0, the day of week, day of month and month registers are 1, and `uip` and `updEnded` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle enable per time-base tick |
| setHold | input | 1 | Freeze bit: stops register advances |
| divSel | input | 3 | Divider field: 000–010 run, 011–101 stop, 11x reset |
| dataBinary | input | 1 | 1 = binary, 0 = packed decimal |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| wrEn | input | 8 | Per-register load strobes (index order in R11) |
| wrData | input | 8 | Load value |
| secOut | output | 8 | Seconds register |
| minOut | output | 8 | Minutes register |
| hourOut | output | 8 | Hours register |
| wdayOut | output | 8 | Day-of-week register |
| mdayOut | output | 8 | Day-of-month register |
| monthOut | output | 8 | Month register |
| yearOut | output | 8 | Year register |
| centuryOut | output | 8 | Century register |
| uip | output | 1 | Update-warning flag |
| updEnded | output | 1 | Advance pulse |

## Verification
The bench builds the block with TICKS_PER_SEC = 16 and UIP_TICKS = 3, so one second costs sixteen clocks. At that rate it can afford three exhaustive sweeps: every hour of the day in both hour formats and both number formats, every month end across leap, non-leap and century years, and a full minute of seconds. The same short second makes it cheap to check the warning window tick by tick, the half-second restart after the divider reset, and a load landing on the exact advance edge.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int NUM_REGS = 8;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_WDAY = 3;
  localparam int IDX_MDAY = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;
  localparam int IDX_CENT = 7;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic advance;  // registers move one second this edge
    logic uip;      // update-warning window is open
  } todStrobe_t;

  // Stored code to plain value.
  function automatic logic [7:0] fromCode(logic [7:0] v, logic bin);
    if (bin) return v;
    return 8'(32'(v[7:4]) * 10 + 32'(v[3:0]));
  endfunction

  // Plain value to stored code.
  function automatic logic [7:0] toCode(logic [7:0] v, logic bin);
    if (bin) return v;
    return {4'(v / 8'd10), 4'(v % 8'd10)};
  endfunction

  function automatic logic [7:0] monthLength(logic [7:0] mon, logic leap);
    case (mon)
      8'd2:                         return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:      return 8'd30;
      default:                      return 8'd31;
    endcase
  endfunction

  function automatic logic [7:0] resetValue(int idx);
    if (idx == IDX_WDAY || idx == IDX_MDAY || idx == IDX_MON) return 8'd1;
    return 8'd0;
  endfunction

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                setHold,
  input  logic [2:0]          divSel,
  output tod_pkg::todStrobe_t strb,
  output logic                updEnded
);
  localparam int CNT_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(TICKS_PER_SEC - 1);
  localparam logic [CNT_W-1:0] HALF_CNT  = CNT_W'(TICKS_PER_SEC / 2);
  localparam logic [CNT_W-1:0] UIP_START = CNT_W'(TICKS_PER_SEC - UIP_TICKS);

  logic [CNT_W-1:0] cnt;
  logic divReset, divOk, atLast, secondEdge;

  assign divReset   = (divSel[2:1] == 2'b11);
  assign divOk      = (divSel <= 3'd2);
  assign atLast     = (cnt == LAST_CNT);
  assign secondEdge = divOk && tickEn && atLast;

  always_comb begin
    strb.advance = secondEdge && !setHold;
    strb.uip     = divOk && !setHold && (cnt >= UIP_START);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      updEnded <= 1'b0;
    end else begin
      updEnded <= strb.advance;
      if (divReset)
        cnt <= HALF_CNT;            // restart lands half a second out
      else if (divOk && tickEn)
        cnt <= atLast ? '0 : cnt + 1'b1;
    end
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    secondEdge |=> (cnt == '0));

  p_uip_precedes_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> strb.uip);

  p_reset_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    divReset |-> (!strb.advance && !strb.uip));

  p_reset_half_r3: assert property (@(posedge clk) disable iff (!rstN)
    divReset |=> (cnt == HALF_CNT));

  p_stopped_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!divOk && !divReset) |=> $stable(cnt));

  p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rstN)
    updEnded |=> !updEnded);

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int NREG = tod_pkg::NUM_REGS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  todStrobe_t                 strb,
  input  logic                       dataBinary,
  input  logic                       hour24,
  input  logic [NREG-1:0]            wrEn,
  input  logic [7:0]                 wrData,
  output logic [NREG-1:0][7:0]       regQ
);
  logic [NREG-1:0][7:0] nextVal;
  logic [NREG-1:0]      updEn;

  logic [7:0] secB, minB, hourLow, hour24Cur, wdayB, mdayB, monB, yrB, cenB;
  logic [7:0] secN, minN, hourN, wdayN, mdayN, monN, yrN, cenN;
  logic [7:0] dimCur, hour12N;
  logic secWrap, minWrap, hourWrap, mdayWrap, monWrap, yrWrap, leap;

  // Decode every field to a plain value.
  always_comb begin
    secB    = fromCode(regQ[IDX_SEC],  dataBinary);
    minB    = fromCode(regQ[IDX_MIN],  dataBinary);
    hourLow = fromCode({1'b0, regQ[IDX_HOUR][6:0]}, dataBinary);
    if (hour24)
      hour24Cur = fromCode(regQ[IDX_HOUR], dataBinary);
    else
      hour24Cur = (hourLow % 8'd12) + (regQ[IDX_HOUR][7] ? 8'd12 : 8'd0);
    wdayB   = fromCode(regQ[IDX_WDAY], dataBinary);
    mdayB   = fromCode(regQ[IDX_MDAY], dataBinary);
    monB    = fromCode(regQ[IDX_MON],  dataBinary);
    yrB     = fromCode(regQ[IDX_YEAR], dataBinary);
    cenB    = fromCode(regQ[IDX_CENT], dataBinary);
  end

  // Carry chain, all in one cycle.
  always_comb begin
    leap     = ((yrB % 8'd4) == 8'd0) && ((yrB != 8'd0) || ((cenB % 8'd4) == 8'd0));
    dimCur   = monthLength(monB, leap);

    secWrap  = (secB >= 8'd59);
    secN     = secWrap ? 8'd0 : secB + 8'd1;

    minWrap  = secWrap && (minB >= 8'd59);
    minN     = (minB >= 8'd59) ? 8'd0 : minB + 8'd1;

    hourWrap = minWrap && (hour24Cur >= 8'd23);
    hourN    = (hour24Cur >= 8'd23) ? 8'd0 : hour24Cur + 8'd1;

    wdayN    = (wdayB >= 8'd7) ? 8'd1 : wdayB + 8'd1;

    mdayWrap = hourWrap && (mdayB >= dimCur);
    mdayN    = (mdayB >= dimCur) ? 8'd1 : mdayB + 8'd1;

    monWrap  = mdayWrap && (monB >= 8'd12);
    monN     = (monB >= 8'd12) ? 8'd1 : monB + 8'd1;

    yrWrap   = monWrap && (yrB >= 8'd99);
    yrN      = (yrB >= 8'd99) ? 8'd0 : yrB + 8'd1;

    cenN     = (cenB >= 8'd99) ? 8'd0 : cenB + 8'd1;

    hour12N  = ((hourN % 8'd12) == 8'd0) ? 8'd12 : (hourN % 8'd12);
  end

  // Re-encode and select which fields move.
  always_comb begin
    nextVal[IDX_SEC]  = toCode(secN, dataBinary);
    nextVal[IDX_MIN]  = toCode(minN, dataBinary);
    if (hour24)
      nextVal[IDX_HOUR] = toCode(hourN, dataBinary);
    else
      nextVal[IDX_HOUR] = toCode(hour12N, dataBinary) | ((hourN >= 8'd12) ? 8'h80 : 8'h00);
    nextVal[IDX_WDAY] = toCode(wdayN, dataBinary);
    nextVal[IDX_MDAY] = toCode(mdayN, dataBinary);
    nextVal[IDX_MON]  = toCode(monN,  dataBinary);
    nextVal[IDX_YEAR] = toCode(yrN,   dataBinary);
    nextVal[IDX_CENT] = toCode(cenN,  dataBinary);

    updEn[IDX_SEC]  = strb.advance;
    updEn[IDX_MIN]  = strb.advance && secWrap;
    updEn[IDX_HOUR] = strb.advance && minWrap;
    updEn[IDX_WDAY] = strb.advance && hourWrap;
    updEn[IDX_MDAY] = strb.advance && hourWrap;
    updEn[IDX_MON]  = strb.advance && mdayWrap;
    updEn[IDX_YEAR] = strb.advance && monWrap;
    updEn[IDX_CENT] = strb.advance && yrWrap;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rstN)
        regQ[i] <= resetValue(i);
      else if (wrEn[i])
        regQ[i] <= wrData;
      else if (updEn[i])
        regQ[i] <= nextVal[i];
    end
  end

  p_sec_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !wrEn[IDX_SEC]) |=> $stable(regQ[IDX_SEC]));

  p_load_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    wrEn[IDX_SEC] |=> (regQ[IDX_SEC] == $past(wrData)));

  p_sec_moves_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !wrEn[IDX_SEC]) |=> (regQ[IDX_SEC] != $past(regQ[IDX_SEC])));

  p_min_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!secWrap && !wrEn[IDX_MIN]) |=> $stable(regQ[IDX_MIN]));

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       setHold,
  input  logic [2:0] divSel,
  input  logic       dataBinary,
  input  logic       hour24,
  input  logic [7:0] wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] secOut,
  output logic [7:0] minOut,
  output logic [7:0] hourOut,
  output logic [7:0] wdayOut,
  output logic [7:0] mdayOut,
  output logic [7:0] monthOut,
  output logic [7:0] yearOut,
  output logic [7:0] centuryOut,
  output logic       uip,
  output logic       updEnded
);
  import tod_pkg::*;

  todStrobe_t                strb;
  logic [NUM_REGS-1:0][7:0]  regQ;

  tod_ctrl #(
    .TICKS_PER_SEC(TICKS_PER_SEC),
    .UIP_TICKS    (UIP_TICKS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .setHold  (setHold),
    .divSel   (divSel),
    .strb     (strb),
    .updEnded (updEnded)
  );

  tod_datapath #(
    .NREG(NUM_REGS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataBinary (dataBinary),
    .hour24     (hour24),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .regQ       (regQ)
  );

  assign secOut     = regQ[IDX_SEC];
  assign minOut     = regQ[IDX_MIN];
  assign hourOut    = regQ[IDX_HOUR];
  assign wdayOut    = regQ[IDX_WDAY];
  assign mdayOut    = regQ[IDX_MDAY];
  assign monthOut   = regQ[IDX_MON];
  assign yearOut    = regQ[IDX_YEAR];
  assign centuryOut = regQ[IDX_CENT];
  assign uip        = strb.uip;

endmodule

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TPS  = 16;
  localparam int UIPT = 3;
  localparam int HALF = TPS / 2;

  logic       clk = 1'b0;
  logic       rstN, tickEn, setHold, dataBinary, hour24;
  logic [2:0] divSel;
  logic [7:0] wrEn, wrData;
  logic [7:0] secOut, minOut, hourOut, wdayOut, mdayOut, monthOut, yearOut, centuryOut;
  logic       uip, updEnded;

  int checks = 0;
  int failures = 0;

  tod_calendar #(.TICKS_PER_SEC(TPS), .UIP_TICKS(UIPT)) u_tod_calendar (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .setHold(setHold), .divSel(divSel),
    .dataBinary(dataBinary), .hour24(hour24), .wrEn(wrEn), .wrData(wrData),
    .secOut(secOut), .minOut(minOut), .hourOut(hourOut), .wdayOut(wdayOut),
    .mdayOut(mdayOut), .monthOut(monthOut), .yearOut(yearOut),
    .centuryOut(centuryOut), .uip(uip), .updEnded(updEnded));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] enc(int v, bit bin);
    if (bin) return 8'(v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] encHr(int h, bit bin, bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int dimOf(int m, int y, int c);
    int full;
    bit lp;
    full = c * 100 + y;
    lp = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (m == 2) return lp ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic writeReg(int idx, logic [7:0] d);
    @(negedge clk);
    wrEn = 8'(1 << idx);
    wrData = d;
    @(negedge clk);
    wrEn = 8'h00;
  endtask

  task automatic setTime(bit bin, bit h24, int s, int mi, int h, int wd,
                         int md, int mo, int y, int c);
    dataBinary = bin;
    hour24 = h24;
    writeReg(0, enc(s, bin));
    writeReg(1, enc(mi, bin));
    writeReg(2, encHr(h, bin, h24));
    writeReg(3, enc(wd, bin));
    writeReg(4, enc(md, bin));
    writeReg(5, enc(mo, bin));
    writeReg(6, enc(y, bin));
    writeReg(7, enc(c, bin));
  endtask

  task automatic runTicks(int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; setHold = 1'b0; divSel = 3'b010;
    dataBinary = 1'b0; hour24 = 1'b1; wrEn = 8'h00; wrData = 8'h00;
    repeat (3) @(negedge clk);

    // R13 reset state
    chk("R13 sec", 32'(secOut), 32'h0);
    chk("R13 min", 32'(minOut), 32'h0);
    chk("R13 hour", 32'(hourOut), 32'h0);
    chk("R13 wday", 32'(wdayOut), 32'h1);
    chk("R13 mday", 32'(mdayOut), 32'h1);
    chk("R13 month", 32'(monthOut), 32'h1);
    chk("R13 year", 32'(yearOut), 32'h0);
    chk("R13 century", 32'(centuryOut), 32'h0);
    chk("R13 uip", 32'(uip), 32'h0);
    chk("R13 updEnded", 32'(updEnded), 32'h0);
    rstN = 1'b1;

    // R1, R2, R12: one second tick by tick
    @(negedge clk);
    tickEn = 1'b1;
    for (int k = 1; k <= TPS; k++) begin
      @(negedge clk);
      chk("R2 uip window", 32'(uip), 32'(((k % TPS) >= TPS - UIPT) ? 1 : 0));
      chk("R12 pulse timing", 32'(updEnded), 32'((k == TPS) ? 1 : 0));
      chk("R1 sec at tick", 32'(secOut), 32'((k == TPS) ? 1 : 0));
    end
    tickEn = 1'b0;
    @(negedge clk);
    chk("R12 pulse one cycle", 32'(updEnded), 32'h0);

    // R6, R8: a full minute of seconds in both number formats
    for (int b = 0; b < 2; b++) begin
      setTime(bit'(b), 1'b1, 0, 7, 3, 2, 9, 4, 21, 20);
      for (int s = 1; s <= 60; s++) begin
        runTicks(TPS);
        chk("R6 sec code", 32'(secOut), 32'(enc(s % 60, bit'(b))));
        chk("R8 min carry", 32'(minOut), 32'(enc((s == 60) ? 8 : 7, bit'(b))));
      end
    end

    // R7, R8: every hour rollover, both hour formats and number formats
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        for (int h = 0; h < 24; h++) begin
          setTime(bit'(b), bit'(f), 59, 59, h, 3, 10, 5, 30, 20);
          runTicks(TPS);
          chk("R7 hour code", 32'(hourOut), 32'(encHr((h + 1) % 24, bit'(b), bit'(f))));
          chk("R8 min wrap", 32'(minOut), 32'h0);
          chk("R8 day carry", 32'(mdayOut), 32'(enc((h == 23) ? 11 : 10, bit'(b))));
        end

    // R9, R10: month ends across leap and century years
    for (int b = 0; b < 2; b++)
      for (int yc = 0; yc < 6; yc++) begin
        int y, c;
        case (yc)
          0: begin y = 0;  c = 20; end
          1: begin y = 0;  c = 19; end
          2: begin y = 24; c = 20; end
          3: begin y = 23; c = 20; end
          4: begin y = 99; c = 19; end
          default: begin y = 0; c = 24; end
        endcase
        for (int m = 1; m <= 12; m++)
          for (int e = 0; e < 2; e++) begin
            int d, ed, em, ey, ec;
            d  = dimOf(m, y, c) - 1 + e;
            ed = (e == 1) ? 1 : d + 1;
            em = (e == 1) ? ((m == 12) ? 1 : m + 1) : m;
            ey = (e == 1 && m == 12) ? ((y == 99) ? 0 : y + 1) : y;
            ec = (e == 1 && m == 12 && y == 99) ? c + 1 : c;
            setTime(bit'(b), 1'b1, 59, 59, 23, 7, d, m, y, c);
            runTicks(TPS);
            chk("R9 mday", 32'(mdayOut), 32'(enc(ed, bit'(b))));
            chk("R10 month", 32'(monthOut), 32'(enc(em, bit'(b))));
            chk("R10 year", 32'(yearOut), 32'(enc(ey, bit'(b))));
            chk("R10 century", 32'(centuryOut), 32'(enc(ec, bit'(b))));
            chk("R10 wday", 32'(wdayOut), 32'(enc(1, bit'(b))));
          end
      end

    // R5: freeze bit
    setTime(1'b0, 1'b1, 20, 1, 1, 1, 1, 1, 1, 20);
    setHold = 1'b1;
    @(negedge clk);
    tickEn = 1'b1;
    for (int k = 1; k <= TPS; k++) begin
      @(negedge clk);
      chk("R5 no pulse", 32'(updEnded), 32'h0);
      chk("R2 uip frozen", 32'(uip), 32'h0);
    end
    tickEn = 1'b0;
    chk("R5 sec frozen", 32'(secOut), 32'h20);
    setHold = 1'b0;
    runTicks(TPS);
    chk("R5 phase kept", 32'(updEnded), 32'h1);
    chk("R5 resumes", 32'(secOut), 32'h21);

    // R4: stopped divider
    divSel = 3'b011;
    runTicks(2 * TPS);
    chk("R4 no advance", 32'(secOut), 32'h21);
    chk("R4 uip off", 32'(uip), 32'h0);
    divSel = 3'b001;
    runTicks(TPS);
    chk("R4 resumes", 32'(secOut), 32'h22);
    chk("R4 pulse", 32'(updEnded), 32'h1);

    // R3: divider reset and half-second release
    divSel = 3'b110;
    runTicks(2 * TPS);
    chk("R3 held", 32'(secOut), 32'h22);
    chk("R3 uip held", 32'(uip), 32'h0);
    divSel = 3'b111;
    runTicks(3);
    chk("R3 held 111", 32'(secOut), 32'h22);
    divSel = 3'b010;
    runTicks(HALF - 1);
    chk("R3 not yet", 32'(secOut), 32'h22);
    runTicks(1);
    chk("R3 half second", 32'(secOut), 32'h23);
    chk("R3 pulse", 32'(updEnded), 32'h1);

    // R11: load on the advance edge wins for its own register
    setTime(1'b0, 1'b1, 59, 5, 1, 1, 1, 1, 1, 20);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (TPS - 1) @(negedge clk);
    wrEn = 8'h01;
    wrData = 8'h42;
    @(negedge clk);
    wrEn = 8'h00;
    tickEn = 1'b0;
    chk("R11 load wins", 32'(secOut), 32'h42);
    chk("R11 others advance", 32'(minOut), 32'h06);
    chk("R11 pulse", 32'(updEnded), 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule